// File: doc/BRIEF.md
# Keyed Watchdog Timer

The block is a watchdog peripheral on a 32-bit register bus. A 16-bit counter counts upward once per prescaled tick of the timer clock enable while the timer is enabled. When the counter rolls from 0xFFFF to 0 it raises a system reset request pulse and sets a sticky overflow flag. Software keeps the system alive by reloading the counter well before that rollover. The time left is always 65536 minus the current count, in prescaled ticks.

Every write must carry a key in its upper bits, and the key depends on the register. A write with the wrong key is dropped and leaves everything as it was, so a stray store cannot stop or reload the watchdog. A write-pending status bit shows software when an accepted write has settled in the timer's counting domain. The overflow flag sits on the power-on reset only, so it survives the reset that the watchdog itself causes and can be read afterwards as the reset cause.

Top module: `keyed_wdt`

## Requirements
- R1: Reads return zeros above the register width. Byte offset 0x0 returns the count in bits [15:0]. Offset 0x4 returns control A: bit 7 timer enable, bit 5 write pending, bit 4 overflow flag, bits [2:0] divider index, and all other bits 0. Offset 0x8 returns the 8-bit control B value in bits [7:0].
- R2: A write to offset 0x0 is accepted only when bits [31:16] equal 0x5A5A, and it loads bits [15:0] into the counter.
- R3: A write to offset 0x4 or 0x8 is accepted only when bits [31:8] equal 0xA5A5A5. Any write with the wrong key changes no register and does not set the write-pending bit.
- R4: After reset all registers read 0 and the reset request is low.
- R5: An accepted write sets the write-pending bit. The bit clears after exactly two cycles in which the timer clock enable is high, and it holds while that enable is low.
- R6: The counter does not change while the timer enable bit is 0, except through a write.
- R7: The divider index selects 1, 4, 16, 32, 64, 128, 1024 or 4096 timer enable pulses per count step, for index 0 to 7.
- R8: On rollover from 0xFFFF the counter becomes 0, the overflow flag sets, and the reset request goes high for exactly 16 clock cycles, starting right after the rollover edge.
- R9: The overflow flag keeps its value through the block reset (rst_n) and is cleared only by the power-on reset or by an accepted control A write with bit 4 at 0. Writing 1 to bit 4 never sets it.
- R10: With 0xFFFF loaded, divider index 0 and the enable pulse held high, enabling the timer raises the reset request on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including the overflow flag |
| rst_n | input | 1 | Block reset, active low; leaves the overflow flag alone |
| tick_en | input | 1 | Timer clock enable, one pulse per timer clock cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data including the key |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data of the addressed register |
| rst_req | output | 1 | System reset request pulse |

## Verification
A write takes effect on the clock edge that samples it, so read-back, the write-pending bit and the key checks are examined at the falling edge right after that edge. Count results are due a fixed number of edges after the enabling write: with divider D the count after N edges is N/D rounded down. The bench waits exactly N falling edges before it reads. On rollover the flag and the reset request change on the edge after the enabling write, and the pulse is then sampled on each of the next 16 falling edges and once more to see it drop. The write-pending bit is checked after one and after two timer enable pulses, and again while that enable is held low.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int CNT_W   = 16;
  localparam int PSC_W   = 12;
  localparam int DIV_IDX_W = 3;
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;
  localparam int OFS_COUNT = 0;
  localparam int OFS_CTLA  = 4;
  localparam int OFS_CTLB  = 8;
  localparam int BIT_EN    = 7;
  localparam int BIT_WIP   = 5;
  localparam int BIT_OVF   = 4;

  // Prescaler terminal value (divider minus one) for each divider index
  function automatic logic [PSC_W-1:0] div_limit(input logic [DIV_IDX_W-1:0] idx);
    logic [PSC_W-1:0] lim;
    case (idx)
      3'd0:    lim = PSC_W'(0);
      3'd1:    lim = PSC_W'(3);
      3'd2:    lim = PSC_W'(15);
      3'd3:    lim = PSC_W'(31);
      3'd4:    lim = PSC_W'(63);
      3'd5:    lim = PSC_W'(127);
      3'd6:    lim = PSC_W'(1023);
      default: lim = PSC_W'(4095);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_we,
  input  logic [CNT_W-1:0]     cnt_val,
  input  logic                 ovf_flag,
  output logic [31:0]          bus_rdata,
  output logic                 cnt_load,
  output logic [CNT_W-1:0]     cnt_load_val,
  output logic                 tmr_en,
  output logic [DIV_IDX_W-1:0] div_sel,
  output logic                 ovf_clr,
  output logic                 wip
);
  localparam int WIP_CYC = 2;
  localparam int WIP_W   = $clog2(WIP_CYC + 1);

  logic                 hit_cnt, hit_cta, hit_ctb;
  logic                 key_cnt_ok, key_ctl_ok;
  logic                 wr_cnt, wr_cta, wr_ctb, wr_any;
  logic                 en_q, en_d;
  logic [DIV_IDX_W-1:0] div_q, div_d;
  logic [7:0]           ctlb_q, ctlb_d;
  logic [WIP_W-1:0]     wip_q, wip_d;
  logic                 unused_bits;

  assign hit_cnt    = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_cta    = (bus_addr == ADDR_W'(OFS_CTLA));
  assign hit_ctb    = (bus_addr == ADDR_W'(OFS_CTLB));
  assign key_cnt_ok = (bus_wdata[31:16] == CNT_KEY);
  assign key_ctl_ok = (bus_wdata[31:8] == CTL_KEY);
  assign wr_cnt     = bus_we && hit_cnt && key_cnt_ok;
  assign wr_cta     = bus_we && hit_cta && key_ctl_ok;
  assign wr_ctb     = bus_we && hit_ctb && key_ctl_ok;
  assign wr_any     = wr_cnt || wr_cta || wr_ctb;
  assign unused_bits = ^{bus_wdata[6:5], bus_wdata[3]};

  // Next-state logic
  always_comb begin
    en_d   = en_q;
    div_d  = div_q;
    ctlb_d = ctlb_q;
    wip_d  = wip_q;
    if (wr_cta) begin
      en_d  = bus_wdata[BIT_EN];
      div_d = bus_wdata[DIV_IDX_W-1:0];
    end
    if (wr_ctb) begin
      ctlb_d = bus_wdata[7:0];
    end
    if (wr_any) begin
      wip_d = WIP_W'(WIP_CYC);
    end else if (tick_en && (wip_q != '0)) begin
      wip_d = wip_q - WIP_W'(1);
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= '0;
      ctlb_q <= '0;
      wip_q  <= '0;
    end else begin
      en_q   <= en_d;
      div_q  <= div_d;
      ctlb_q <= ctlb_d;
      wip_q  <= wip_d;
    end
  end

  assign cnt_load     = wr_cnt;
  assign cnt_load_val = bus_wdata[CNT_W-1:0];
  assign ovf_clr      = wr_cta && !bus_wdata[BIT_OVF];
  assign tmr_en       = en_q;
  assign div_sel      = div_q;
  assign wip          = (wip_q != '0);

  // Read multiplexer
  always_comb begin
    bus_rdata = '0;
    if (hit_cnt) begin
      bus_rdata[CNT_W-1:0] = cnt_val;
    end else if (hit_cta) begin
      bus_rdata[BIT_EN]          = en_q;
      bus_rdata[BIT_WIP]         = wip;
      bus_rdata[BIT_OVF]         = ovf_flag;
      bus_rdata[DIV_IDX_W-1:0]   = div_q;
    end else if (hit_ctb) begin
      bus_rdata[7:0] = ctlb_q;
    end
  end

  AST_BAD_KEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(hit_cnt && key_cnt_ok) && !((hit_cta || hit_ctb) && key_ctl_ok))
    |=> ($stable(en_q) && $stable(div_q) && $stable(ctlb_q))); // R3

  AST_WIP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> wip); // R5

  AST_WIP_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !tick_en && !wr_any) |=> wip); // R5
endmodule

// File: rtl/keyed_wdt_prescaler.sv
module keyed_wdt_prescaler
  import keyed_wdt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 run,
  input  logic                 restart,
  input  logic [DIV_IDX_W-1:0] div_sel,
  output logic                 tick
);
  logic [PSC_W-1:0] psc_q, psc_d;
  logic [PSC_W-1:0] lim;
  logic             at_lim;

  assign lim    = div_limit(div_sel);
  assign at_lim = (psc_q >= lim);
  assign tick   = run && !restart && tick_en && at_lim;

  always_comb begin
    psc_d = psc_q;
    if (!run || restart) begin
      psc_d = '0;
    end else if (tick_en) begin
      psc_d = at_lim ? '0 : psc_q + PSC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
    end else begin
      psc_q <= psc_d;
    end
  end

  AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (tick_en && run)); // R7
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core
  import keyed_wdt_pkg::*;
#(
  parameter int PULSE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_n,
  input  logic             tmr_en,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_flag,
  output logic             rst_req
);
  localparam int PC_W = $clog2(PULSE_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             ovf_q, ovf_d;
  logic             wrap;

  assign wrap = tick && !cnt_load && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_load) begin
      cnt_d = cnt_load_val;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    pc_d = pc_q;
    if (wrap) begin
      pc_d = PC_W'(PULSE_W);
    end else if (pc_q != '0) begin
      pc_d = pc_q - PC_W'(1);
    end
    ovf_d = ovf_q;
    if (wrap) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pc_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
    end
  end

  // Overflow cause lives on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign cnt      = cnt_q;
  assign ovf_flag = ovf_q;
  assign rst_req  = (pc_q != '0);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en && !cnt_load) |=> $stable(cnt_q)); // R6

  AST_REQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> (ovf_flag && (cnt_q == '0))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (ovf_q && !ovf_clr) |=> ovf_q); // R9
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int PULSE_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req
);
  localparam int NRST = 2;

  logic [NRST-1:0] rst_raw, rst_sync;
  logic            blk_rst_n, por_sync_n;

  assign rst_raw[0] = rst_n && por_n;
  assign rst_raw[1] = por_n;

  // Asynchronous assertion, synchronous release, one stage chain per reset
  for (genvar g = 0; g < NRST; g++) begin : g_rsync
    logic [SYNC_N-1:0] ff;
    always_ff @(posedge clk or negedge rst_raw[g]) begin
      if (!rst_raw[g]) begin
        ff <= '0;
      end else begin
        ff <= {ff[SYNC_N-2:0], 1'b1};
      end
    end
    assign rst_sync[g] = ff[SYNC_N-1];
  end

  assign blk_rst_n  = rst_sync[0];
  assign por_sync_n = rst_sync[1];

  logic [CNT_W-1:0]     cnt_val, cnt_load_val;
  logic                 cnt_load, tmr_en, ovf_flag, ovf_clr, wip, tick;
  logic [DIV_IDX_W-1:0] div_sel;

  keyed_wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (blk_rst_n),
    .tick_en      (tick_en),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_we       (bus_we),
    .cnt_val      (cnt_val),
    .ovf_flag     (ovf_flag),
    .bus_rdata    (bus_rdata),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .tmr_en       (tmr_en),
    .div_sel      (div_sel),
    .ovf_clr      (ovf_clr),
    .wip          (wip)
  );

  keyed_wdt_prescaler u_psc (
    .clk     (clk),
    .rst_n   (blk_rst_n),
    .tick_en (tick_en),
    .run     (tmr_en),
    .restart (cnt_load),
    .div_sel (div_sel),
    .tick    (tick)
  );

  keyed_wdt_core #(.PULSE_W(PULSE_W)) u_core (
    .clk          (clk),
    .rst_n        (blk_rst_n),
    .por_n        (por_sync_n),
    .tmr_en       (tmr_en),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .tick         (tick),
    .ovf_clr      (ovf_clr),
    .cnt          (cnt_val),
    .ovf_flag     (ovf_flag),
    .rst_req      (rst_req)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!por_sync_n)
    !blk_rst_n |-> !rst_req); // R4
endmodule

// File: tb/tb_keyed_wdt.sv
`timescale 1ns/1ps
module tb_keyed_wdt;
  logic        clk = 1'b0;
  logic        por_n, rst_n, tick_en, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rst_req;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  keyed_wdt dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_en(tick_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    wr(4'h0, {16'h5A5A, v});
  endtask

  task automatic wr_a(input logic [7:0] v);
    wr(4'h4, {24'hA5A5A5, v});
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); chk("R4 count", d, 0);
    rd(4'h4, d); chk("R4 ctrlA", d, 0);
    rd(4'h8, d); chk("R4 ctrlB", d, 0);
    chk("R4 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic t_keys;
    logic [31:0] d;
    wr(4'h0, 32'h5A5B_0077); settle(3);
    rd(4'h0, d); chk("R3 bad count key", d, 0);
    wr(4'h4, 32'hA5A5A4_85); rd(4'h4, d); chk("R3 bad ctrlA key, no wip", d, 0);
    wr(4'h8, 32'h1234_5633); rd(4'h8, d); chk("R3 bad ctrlB key", d, 0);
    wr(4'h8, 32'hA5A5A5_C3); rd(4'h8, d); chk("R1 R3 ctrlB readback", d, 32'h0000_00C3);
    wr_cnt(16'h1234); settle(3);
    rd(4'h0, d); chk("R2 count load", d, 32'h0000_1234);
    wr(4'h0, 32'hA5A5_A5FF); settle(3);
    rd(4'h0, d); chk("R2 ctrl key on count rejected", d, 32'h0000_1234);
    settle(20);
    rd(4'h0, d); chk("R6 frozen while disabled", d, 32'h0000_1234);
  endtask

  task automatic t_wip;
    logic [31:0] d;
    wr_a(8'h03);
    rd(4'h4, d); chk("R5 wip after 0 pulses", d, 32'h23);
    settle(1); rd(4'h4, d); chk("R5 wip after 1 pulse", d, 32'h23);
    settle(1); rd(4'h4, d); chk("R5 wip after 2 pulses", d, 32'h03);
    tick_en = 1'b0;
    wr_a(8'h00); settle(5);
    rd(4'h4, d); chk("R5 wip held without pulses", d, 32'h20);
    tick_en = 1'b1;
    settle(2); rd(4'h4, d); chk("R5 wip released", d, 32'h00);
  endtask

  task automatic t_div(input logic [2:0] idx, input int div, input int steps);
    logic [31:0] d;
    wr_cnt(16'h0000);
    wr_a({5'b10000, idx});
    settle(div * steps);
    rd(4'h0, d);
    chk($sformatf("R7 divider %0d", div), d, steps);
    wr_a(8'h00);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    wr_cnt(16'hFFFF);
    wr_a(8'h80);
    rd(4'h0, d); chk("R10 count before edge", d, 32'h0000_FFFF);
    chk("R10 no request yet", {31'b0, rst_req}, 0);
    for (int i = 1; i <= 16; i++) begin
      settle(1);
      chk($sformatf("R8 R10 request cycle %0d", i), {31'b0, rst_req}, 1);
      if (i == 1) begin
        rd(4'h0, d); chk("R8 wrap to zero", d, 0);
        rd(4'h4, d); chk("R8 flag set", d & 32'h10, 32'h10);
      end
    end
    settle(1);
    chk("R8 request ends after 16", {31'b0, rst_req}, 0);
    wr_a(8'h10);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    @(negedge clk); rst_n = 1'b0;
    settle(3); rst_n = 1'b1; settle(4);
    rd(4'h4, d); chk("R9 flag survives block reset", d, 32'h10);
    rd(4'h0, d); chk("R4 count cleared by block reset", d, 0);
    wr_a(8'h10); settle(3);
    rd(4'h4, d); chk("R9 writing 1 keeps flag", d, 32'h10);
    wr_a(8'h00); settle(3);
    rd(4'h4, d); chk("R9 writing 0 clears flag", d, 0);
    wr_a(8'h10); settle(3);
    rd(4'h4, d); chk("R9 writing 1 does not set", d, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; tick_en = 1'b1;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    settle(4);
    por_n = 1'b1; rst_n = 1'b1;
    settle(4);
    t_reset();
    t_keys();
    t_wip();
    t_div(3'd0, 1, 10);
    t_div(3'd1, 4, 5);
    t_div(3'd2, 16, 5);
    t_div(3'd3, 32, 2);
    t_div(3'd6, 1024, 2);
    t_div(3'd7, 4096, 1);
    t_overflow();
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule